// File: doc/BRIEF.md
# Scrubber Controller Health Supervisor

This block watches the status outputs of a configuration-memory soft-error scrubbing controller. It raises a latched fault, with a cause code, when that controller stops behaving as expected. Each die region supplies its own set of one-hot state indicators and its own heartbeat pulse. All regions share one active-low CRC failure flag. The block runs several timers: one for boot completion, one for heartbeat gaps in each region, one for Correction and Classification dwell in each region, and one for the reaction to the CRC flag. Which checks apply depends on the watched controller's state and on the deployment mode.

The deployment mode is a static strap. Code 0 selects mitigation, where the controller boots into Observation and answers a CRC flag by moving to Correction. Code 1 selects detect-only, where the controller boots into Detect-only and answers a CRC flag by moving to Idle. Code 2 selects a directed start into Idle. Code 3 behaves like code 0. The state indicators, the heartbeats and the CRC flag each pass through two flip-flops before any check uses them. A synchronous clear input drops the fault, the cause code, the stopped flag and every running timer.

Top module: `scrub_health_mon`

State decoding uses the per-region vector v = {unc, ess, inj, cls, corr, obs, init}, with v[0] = init:
- Idle is v = 0.
- Init is v = 0000001.
- Observation is v = 0000010.
- Detect-only is v = 0010010.
- Diagnostic Scan is v = 0000011.
- Correction is corr set with init, obs, cls and inj clear.
- Classification is cls set with init, obs, corr and inj clear.
- Halt is all seven bits set.

The fault cause codes are:
- 0: none
- 1: halt
- 2: boot timeout
- 3: heartbeat gap
- 4: dwell timeout
- 5: CRC not answered

## Requirements
- R1: Every state indicator, heartbeat and CRC flag input is seen by the checks two clock edges after it is sampled, so an input first presented before edge k can change the outputs at edge k+2 at the earliest.
- R2: When any region shows all seven indicators set (Halt), fault rises with cause 1 and mit_stopped rises.
- R3: If some region has not yet reached the boot target of the mode (Observation for mode 0 or 3, Detect-only for mode 1, Idle for mode 2) after BOOT_LIMIT consecutive cycles out of reset, fault rises with cause 2. A region that reaches the target in time raises nothing.
- R4: A region that spends HB_GAP consecutive cycles in Observation, Detect-only or Diagnostic Scan without a heartbeat raises fault with cause 3.
- R5: In any other state, the heartbeat is ignored: a missing heartbeat for any length of time raises no fault.
- R6: A region that holds Correction, or holds Classification, for ONE_SEC consecutive cycles raises fault with cause 4.
- R7: In mode 0, if the CRC flag (crc_err_n low) stays asserted for ONE_SEC consecutive cycles while every region stays in Observation, fault rises with cause 5. A move of any region to Correction before that raises nothing.
- R8: In mode 1, the same rule applies with Detect-only as the watched state, and a move to Idle is the accepted answer.
- R9: Outside the watched state, the CRC flag is ignored: held asserted longer than ONE_SEC during Injection, it raises no fault.
- R10: In modes 0, 1 and 3, a region that enters Idle after it has booted sets mit_stopped without raising fault. In mode 2, Idle never sets mit_stopped.
- R11: Reset leaves fault, fault_cause and mit_stopped at 0. A fault holds its first cause until clr. When several causes arrive in the same cycle, the lowest code wins. clr clears fault, cause, mit_stopped and all timers.
- R12: Each region is watched independently. A halt or heartbeat gap in any one region raises the fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| clr | input | 1 | synchronous clear of fault, cause, stopped flag and timers |
| mode | input | 2 | deployment mode strap (0 mitigation, 1 detect-only, 2 idle start) |
| st_init | input | NREG | initialization indicator per region |
| st_obs | input | NREG | observation indicator per region |
| st_corr | input | NREG | correction indicator per region |
| st_cls | input | NREG | classification indicator per region |
| st_inj | input | NREG | injection indicator per region |
| st_ess | input | NREG | essential indicator per region |
| st_unc | input | NREG | uncorrectable indicator per region |
| hb | input | NREG | heartbeat pulse per region |
| crc_err_n | input | 1 | CRC failure flag, active low, shared by all regions |
| fault | output | 1 | latched fault |
| fault_cause | output | 3 | cause code of the latched fault |
| mit_stopped | output | 1 | mitigation has stopped (halt, or idle after boot) |

## Verification
Every timer feeds only the one latched fault and its cause. A counter that starts late, restarts wrongly or compares against the wrong limit therefore appears at the ports as a fault edge that is early or late by exactly that error. It can also appear as a fault carrying the wrong cause code. A wrong state decode appears as a fault where none is due, or as a missing fault, no later than the limit of the timer involved. A wrong synchroniser depth shifts the halt response away from its fixed two-cycle latency.

// File: rtl/scrub_health_mon.sv
module scrub_health_mon #(
  parameter int NREG      = 1,
  parameter int ONE_SEC   = 50_000_000,
  parameter int HB_GAP    = 200_000,
  parameter int BOOT_LIMIT = 100_000_000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [1:0]      mode,
  input  logic [NREG-1:0] st_init,
  input  logic [NREG-1:0] st_obs,
  input  logic [NREG-1:0] st_corr,
  input  logic [NREG-1:0] st_cls,
  input  logic [NREG-1:0] st_inj,
  input  logic [NREG-1:0] st_ess,
  input  logic [NREG-1:0] st_unc,
  input  logic [NREG-1:0] hb,
  input  logic            crc_err_n,
  output logic            fault,
  output logic [2:0]      fault_cause,
  output logic            mit_stopped
);
  localparam int MAXL = (ONE_SEC > HB_GAP) ? ((ONE_SEC > BOOT_LIMIT) ? ONE_SEC : BOOT_LIMIT)
                                           : ((HB_GAP > BOOT_LIMIT) ? HB_GAP : BOOT_LIMIT);
  localparam int CW = $clog2(MAXL + 1);
  localparam logic [CW-1:0] L_SEC  = CW'(ONE_SEC);
  localparam logic [CW-1:0] L_HB   = CW'(HB_GAP);
  localparam logic [CW-1:0] L_BOOT = CW'(BOOT_LIMIT);

  function automatic logic [CW-1:0] run_nxt(input logic [CW-1:0] c, input logic cond,
                                            input logic [CW-1:0] lim);
    if (!cond) return '0;
    return (c >= lim) ? c : c + 1'b1;
  endfunction

  logic [6:0]      s1 [NREG];
  logic [6:0]      s2 [NREG];
  logic [NREG-1:0] hb1, hb2;
  logic            crc1, crc2;

  logic [NREG-1:0] booted;
  logic [NREG-1:0] tgt_v, crcw_v, halt_v, stop_v, hbt_v, dwt_v;

  wire det_mode  = (mode == 2'd1);
  wire idle_mode = (mode == 2'd2);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [CW-1:0] hb_c, cor_c, cls_c;
    wire [6:0] v = s2[r];
    wire is_idle = (v == 7'b0000000);
    wire is_obs  = (v == 7'b0000010);
    wire is_det  = (v == 7'b0010010);
    wire is_scan = (v == 7'b0000011);
    wire is_corr = v[2] & ~(v[4] | v[3] | v[1] | v[0]);
    wire is_cls  = v[3] & ~(v[4] | v[2] | v[1] | v[0]);
    wire hb_cond = (is_obs | is_det | is_scan) & ~hb2[r];

    always_ff @(posedge clk) begin
      s1[r] <= {st_unc[r], st_ess[r], st_inj[r], st_cls[r], st_corr[r], st_obs[r], st_init[r]};
      s2[r] <= s1[r];
      if (rst || clr) begin
        hb_c  <= '0;
        cor_c <= '0;
        cls_c <= '0;
      end else begin
        hb_c  <= run_nxt(hb_c, hb_cond, L_HB);
        cor_c <= run_nxt(cor_c, is_corr, L_SEC);
        cls_c <= run_nxt(cls_c, is_cls, L_SEC);
      end
    end

    assign tgt_v[r]  = det_mode ? is_det : (idle_mode ? is_idle : is_obs);
    assign crcw_v[r] = det_mode ? is_det : is_obs;
    assign halt_v[r] = &v;
    assign stop_v[r] = halt_v[r] | (booted[r] & is_idle & ~idle_mode);
    assign hbt_v[r]  = hb_cond && (hb_c == L_HB - 1'b1);
    assign dwt_v[r]  = (is_corr && (cor_c == L_SEC - 1'b1)) ||
                       (is_cls && (cls_c == L_SEC - 1'b1));
  end

  logic [CW-1:0] boot_c, crc_c;
  wire boot_cond = ~&booted;
  wire crc_cond  = ~crc2 & (&crcw_v);

  wire t_halt = |halt_v;
  wire t_boot = boot_cond && (boot_c == L_BOOT - 1'b1);
  wire t_hb   = |hbt_v;
  wire t_dw   = |dwt_v;
  wire t_crc  = crc_cond && (crc_c == L_SEC - 1'b1);
  wire any_t  = t_halt | t_boot | t_hb | t_dw | t_crc;

  wire [2:0] code = t_halt ? 3'd1 : t_boot ? 3'd2 : t_hb ? 3'd3 : t_dw ? 3'd4 : 3'd5;

  always_ff @(posedge clk) begin
    hb1  <= hb;
    hb2  <= hb1;
    crc1 <= crc_err_n;
    crc2 <= crc1;
    if (rst) booted <= '0;
    else     booted <= booted | tgt_v;
    if (rst || clr) begin
      boot_c      <= '0;
      crc_c       <= '0;
      fault       <= 1'b0;
      fault_cause <= 3'd0;
      mit_stopped <= 1'b0;
    end else begin
      boot_c <= run_nxt(boot_c, boot_cond, L_BOOT);
      crc_c  <= run_nxt(crc_c, crc_cond, L_SEC);
      if (!fault && any_t) begin
        fault       <= 1'b1;
        fault_cause <= code;
      end
      if (|stop_v) mit_stopped <= 1'b1;
    end
  end
endmodule

// File: rtl/scrub_health_mon_chk.sv
module scrub_health_mon_chk #(
  parameter int NREG = 1
) (
  input logic            clk,
  input logic            rst,
  input logic            clr,
  input logic [NREG-1:0] st_init,
  input logic [NREG-1:0] st_obs,
  input logic [NREG-1:0] st_corr,
  input logic [NREG-1:0] st_cls,
  input logic [NREG-1:0] st_inj,
  input logic [NREG-1:0] st_ess,
  input logic [NREG-1:0] st_unc,
  input logic            fault,
  input logic [2:0]      fault_cause,
  input logic            mit_stopped
);
  wire any_halt_in = |(st_init & st_obs & st_corr & st_cls & st_inj & st_ess & st_unc);

  a_r2_halt_faults: assert property (@(posedge clk) disable iff (rst)
    (!clr && $past(any_halt_in, 2)) |=> fault);

  a_r2_halt_stops: assert property (@(posedge clk) disable iff (rst)
    (!clr && $past(any_halt_in, 2)) |=> mit_stopped);

  a_r11_fault_holds: assert property (@(posedge clk) disable iff (rst)
    (fault && !clr) |=> (fault && $stable(fault_cause)));

  a_r11_clear_drops: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!fault && fault_cause == 3'd0 && !mit_stopped));

  a_r11_cause_matches_fault: assert property (@(posedge clk) disable iff (rst)
    (fault == (fault_cause != 3'd0)) && (fault_cause <= 3'd5));
endmodule

bind scrub_health_mon scrub_health_mon_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst(rst), .clr(clr),
  .st_init(st_init), .st_obs(st_obs), .st_corr(st_corr), .st_cls(st_cls),
  .st_inj(st_inj), .st_ess(st_ess), .st_unc(st_unc),
  .fault(fault), .fault_cause(fault_cause), .mit_stopped(mit_stopped)
);

// File: tb/scrub_health_mon_tb_top.sv
module scrub_health_mon_tb_top;
  localparam int NR = 2;
  localparam int SEC = 40;
  localparam int HBG = 40;
  localparam int BOOT = 30;

  logic clk = 0, rst = 1, clr = 0;
  logic [1:0] mode = 0;
  logic [NR-1:0] st_init = 0, st_obs = 0, st_corr = 0, st_cls = 0, st_inj = 0, st_ess = 0, st_unc = 0;
  logic [NR-1:0] hb = 0;
  logic crc_err_n = 1;
  logic fault, mit_stopped;
  logic [2:0] fault_cause;

  int checks = 0, errors = 0;
  bit started = 0;

  always #10 clk = ~clk;

  scrub_health_mon #(.NREG(NR), .ONE_SEC(SEC), .HB_GAP(HBG), .BOOT_LIMIT(BOOT)) dut_i (
    .clk(clk), .rst(rst), .clr(clr), .mode(mode),
    .st_init(st_init), .st_obs(st_obs), .st_corr(st_corr), .st_cls(st_cls),
    .st_inj(st_inj), .st_ess(st_ess), .st_unc(st_unc),
    .hb(hb), .crc_err_n(crc_err_n),
    .fault(fault), .fault_cause(fault_cause), .mit_stopped(mit_stopped));

  // reference model: works on copies of the inputs delayed by two edges
  int m1 [NR], m2 [NR];
  bit h1 [NR], h2 [NR];
  bit c1, c2;
  int hbrun [NR], corrun [NR], clsrun [NR];
  int bootrun, crcrun;
  bit bt [NR];
  bit e_fault, e_stop;
  int e_cause;

  function automatic int vin(int r);
    return {st_unc[r], st_ess[r], st_inj[r], st_cls[r], st_corr[r], st_obs[r], st_init[r]};
  endfunction

  function automatic bit at_target(int v, int md);
    case (md)
      1: return v == 'h12;
      2: return v == 0;
      default: return v == 'h02;
    endcase
  endfunction

  always @(posedge clk) begin
    bit th, tb, thb, tdw, tcrc, allb, allw;
    th = 0; tb = 0; thb = 0; tdw = 0; tcrc = 0; allb = 1; allw = 1;
    for (int r = 0; r < NR; r++) allb &= bt[r];
    if (rst) begin
      e_fault = 0; e_cause = 0; e_stop = 0; bootrun = 0; crcrun = 0;
      for (int r = 0; r < NR; r++) begin bt[r] = 0; hbrun[r] = 0; corrun[r] = 0; clsrun[r] = 0; end
    end else begin
      for (int r = 0; r < NR; r++) begin
        int v;
        bit corr, cls;
        v = m2[r];
        corr = v[2] && v[4:3] == 0 && v[1:0] == 0;
        cls  = v[3] && v[4] == 0 && v[2:0] == 0;
        if ((v == 'h02 || v == 'h12 || v == 'h03) && !h2[r]) hbrun[r]++; else hbrun[r] = 0;
        if (corr) corrun[r]++; else corrun[r] = 0;
        if (cls) clsrun[r]++; else clsrun[r] = 0;
        if (hbrun[r] == HBG) thb = 1;
        if (corrun[r] == SEC || clsrun[r] == SEC) tdw = 1;
        if (v == 'h7f) th = 1;
        if (!((mode == 1) ? (v == 'h12) : (v == 'h02))) allw = 0;
        if (!clr && (v == 'h7f || (bt[r] && v == 0 && mode != 2))) e_stop = 1;
        if (at_target(v, mode)) bt[r] = 1;
      end
      if (!allb) bootrun++; else bootrun = 0;
      if (bootrun == BOOT) tb = 1;
      if (!c2 && allw) crcrun++; else crcrun = 0;
      if (crcrun == SEC) tcrc = 1;
      if (clr) begin
        e_fault = 0; e_cause = 0; e_stop = 0; bootrun = 0; crcrun = 0;
        for (int r = 0; r < NR; r++) begin hbrun[r] = 0; corrun[r] = 0; clsrun[r] = 0; end
      end else if (!e_fault && (th || tb || thb || tdw || tcrc)) begin
        e_fault = 1;
        e_cause = th ? 1 : tb ? 2 : thb ? 3 : tdw ? 4 : 5;
      end
    end
    for (int r = 0; r < NR; r++) begin m2[r] = m1[r]; m1[r] = vin(r); h2[r] = h1[r]; h1[r] = hb[r]; end
    c2 = c1; c1 = crc_err_n;
    started = 1;
  end

  function automatic string tag_of(int c);
    case (c)
      1: return "R2"; 2: return "R3"; 3: return "R4"; 4: return "R6";
      5: return (mode == 1) ? "R8" : "R7";
      default: return "R11";
    endcase
  endfunction

  always @(negedge clk) if (started) begin
    checks++;
    if (fault !== e_fault || fault_cause !== 3'(e_cause)) begin
      errors++;
      $display("FAIL %s model fault/cause actual=%0d/%0d expected=%0d/%0d", tag_of(e_cause),
               fault, fault_cause, e_fault, e_cause);
    end
    if (mit_stopped !== e_stop) begin
      errors++;
      $display("FAIL R10 model mit_stopped actual=%0d expected=%0d", mit_stopped, e_stop);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setst(input int r, input logic [6:0] v);
    {st_unc[r], st_ess[r], st_inj[r], st_cls[r], st_corr[r], st_obs[r], st_init[r]} = v;
  endtask

  task automatic setall(input logic [6:0] v);
    for (int r = 0; r < NR; r++) setst(r, v);
  endtask

  task automatic cyc(input int n, input logic [NR-1:0] hm);
    for (int i = 0; i < n; i++) begin
      hb = (i % 4 == 0) ? hm : '0;
      @(negedge clk);
    end
    hb = '0;
  endtask

  task automatic pulse_clr;
    clr = 1; @(negedge clk); clr = 0;
  endtask

  task automatic do_reset(input logic [1:0] md, input logic [6:0] v);
    rst = 1; mode = md; setall(v); crc_err_n = 1; cyc(4, '0); rst = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset(2'd0, 7'h01);
    chk("R11 reset fault", fault, 0);
    chk("R11 reset cause", fault_cause, 0);
    chk("R11 reset stopped", mit_stopped, 0);
    cyc(5, '0);
    setall(7'h02);
    cyc(40, '1);
    chk("R3 booted in time", fault, 0);

    setall(7'h10); crc_err_n = 0;
    cyc(60, '0);
    chk("R5 R9 injection ignores hb and crc", fault, 0);
    chk("R9 no stop in injection", mit_stopped, 0);

    crc_err_n = 1; setall(7'h02);
    cyc(8, '1);
    crc_err_n = 0; cyc(20, '1);
    setst(0, 7'h04); cyc(5, 2'b10);
    crc_err_n = 1; setst(0, 7'h02); cyc(20, '1);
    chk("R7 answered by correction", fault, 0);

    crc_err_n = 0; cyc(50, '1);
    chk("R7 unanswered crc", fault_cause, 5);
    cyc(10, '1);
    chk("R11 cause held", fault_cause, 5);
    crc_err_n = 1; cyc(4, '1);
    pulse_clr;
    chk("R11 clear fault", fault, 0);
    chk("R11 clear cause", fault_cause, 0);

    cyc(50, 2'b01);
    chk("R4 R12 heartbeat gap region1", fault_cause, 3);
    cyc(4, '1); pulse_clr;

    setst(0, 7'h04); cyc(50, 2'b10);
    chk("R6 correction dwell", fault_cause, 4);
    setst(0, 7'h02); cyc(4, '1); pulse_clr; cyc(4, '1);

    setst(0, 7'h08); cyc(50, 2'b10);
    chk("R6 classification dwell", fault_cause, 4);
    setst(0, 7'h02); cyc(4, '1); pulse_clr; cyc(4, '1);

    setst(1, 7'h7f);
    @(negedge clk);
    chk("R1 halt after one edge", fault, 0);
    @(negedge clk);
    chk("R1 halt after two edges", fault, 0);
    @(negedge clk);
    chk("R1 R2 R12 halt after three edges", fault_cause, 1);
    chk("R2 halt stops", mit_stopped, 1);

    clr = 1; setst(0, 7'h02); setst(1, 7'h04); cyc(4, '0);
    clr = 0; cyc(45, '0);
    chk("R11 same-cycle priority", fault_cause, 3);
    setst(1, 7'h02); cyc(4, '1); pulse_clr; cyc(4, '1);

    setst(0, 7'h00); cyc(5, '1);
    chk("R10 idle after boot stops", mit_stopped, 1);
    chk("R10 idle is not a fault", fault, 0);
    setst(0, 7'h02); cyc(4, '1); pulse_clr; cyc(4, '1);
    chk("R11 clear stopped", mit_stopped, 0);

    do_reset(2'd2, 7'h00);
    cyc(45, '0);
    chk("R3 R10 idle start no fault", fault, 0);
    chk("R10 idle start not stopped", mit_stopped, 0);

    do_reset(2'd1, 7'h01);
    cyc(3, '0); setall(7'h12); cyc(20, '1);
    crc_err_n = 0; cyc(10, '1);
    setall(7'h00); cyc(40, '0);
    chk("R8 answered by idle", fault, 0);
    chk("R10 detect idle stops", mit_stopped, 1);
    crc_err_n = 1; setall(7'h12); cyc(5, '1); pulse_clr; cyc(5, '1);
    crc_err_n = 0; cyc(45, '1);
    chk("R8 unanswered crc", fault_cause, 5);
    crc_err_n = 1;

    do_reset(2'd0, 7'h01);
    cyc(35, '0);
    chk("R3 boot timeout", fault_cause, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule